// File: doc/BRIEF.md
# Transmit Holding Stage with Byte Queue

This block sits between software and the transmit engine of a serial bus target. Software places one byte at a time into a single-entry staging register. Whenever the queue behind it has a free slot, the staged byte moves into a parameterised first-in first-out queue. The bus engine reads the oldest queued byte from a head port and removes it with a pop strobe.

The block drives two live status flags. `hold_empty` is high when software may write; the same level is driven on `tx_irq` for use as an interrupt or DMA request. `fifo_nempty` is high while the queue holds data. Two sticky error flags record faults. `wr_err` records a write made while the staging register is occupied. `undr_err` records a bus read request made while the queue is empty. Software can empty the staging register and the queue together with a one-cycle clear. It clears the sticky flags by writing ones to a clear mask.

Top module: `tx_stage_buf`

## Requirements
- R1: After a synchronous active-low reset, `hold_empty` and `tx_irq` are 1, and `fifo_nempty`, `wr_err` and `undr_err` are 0.
- R2: `tx_irq` equals `hold_empty` on every cycle.
- R3: A write with `hold_empty`=1 and `sw_clr`=0 drives `hold_empty` low on the next cycle.
- R4: When the queue has room, a staged byte moves into the queue one cycle after it was written. On that same edge `hold_empty` returns to 1 and `fifo_nempty` becomes 1.
- R5: While the queue is full, the staged byte stays put and `hold_empty` stays 0. The edge that pops an entry also moves the staged byte in and raises `hold_empty`.
- R6: A write with `hold_empty`=0 and `sw_clr`=0 sets `wr_err` on the next cycle, and its data never reaches the queue.
- R7: `bus_data` shows the oldest queued byte, and each pop advances it in write order.
- R8: `fifo_nempty` falls only on the pop of the last queued entry or on `sw_clr`.
- R9: `bus_rd_req` with `fifo_nempty`=0 sets `undr_err` on the next cycle. With `fifo_nempty`=1 it leaves `undr_err` unchanged.
- R10: `sw_clr` empties the staging register and the queue on one edge and leaves `wr_err` and `undr_err` unchanged. A write in the same cycle is dropped and raises no error.
- R11: In `sw_err_clr`, bit 0 clears `wr_err` and bit 1 clears `undr_err`. If a set event happens in the same cycle, the set wins.
- R12: `bus_pop` while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe into the staging register |
| sw_wr_data | input | DATA_W | Byte written by software |
| sw_clr | input | 1 | Empties the staging register and the queue |
| sw_err_clr | input | 2 | Write-one-to-clear mask: bit 0 clears wr_err, bit 1 clears undr_err |
| bus_pop | input | 1 | Bus engine removes the head entry |
| bus_rd_req | input | 1 | Bus engine requests read data |
| bus_data | output | DATA_W | Oldest queued byte |
| hold_empty | output | 1 | Staging register may be written |
| tx_irq | output | 1 | Transmit request, equal to hold_empty |
| fifo_nempty | output | 1 | Queue holds at least one byte |
| wr_err | output | 1 | Sticky: write made while staging register was occupied |
| undr_err | output | 1 | Sticky: read requested while queue was empty |

## Verification
A fault in the occupancy counter or the pointers shows at the ports within one pop. `bus_data` leaves write order, a byte repeats, or `fifo_nempty` drops while bytes remain. A fault in the staging register's full bit shows one edge after a write. `hold_empty` stays low when the queue has room, or a dropped byte appears at the head. The bench fills the queue to its limit, drains it byte by byte and compares every head value. This exposes off-by-one faults at the wrap and at the full boundary within the drain.

// File: rtl/tx_stage_pkg.sv
// Shared definitions for the transmit staging block.
// Assumes: two sticky error flags, indexed by the constants below.
package tx_stage_pkg;
    localparam int NUM_STICKY = 2;
    localparam int STK_WR     = 0;  // write to occupied staging register
    localparam int STK_UNDR   = 1;  // read request against empty queue
endpackage

// File: rtl/tx_stage_hold.sv
// Single-entry staging register written by software.
// Assumes: 'move' is only asserted while the entry is occupied.
// A write while occupied is rejected and reported on wr_bad.
module tx_stage_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              move,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              wr_bad
);
    logic wr_ok;

    // Classify the write request against the current occupancy.
    always_comb begin
        wr_ok  = wr_en && !full && !clr;
        wr_bad = wr_en &&  full && !clr;
    end

    // Track occupancy; clear outranks write, write outranks move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (clr) begin
            full <= 1'b0;
        end else if (wr_ok) begin
            full <= 1'b1;
        end else if (move) begin
            full <= 1'b0;
        end
    end

    // Capture accepted write data.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            data <= wr_data;
        end
    end
endmodule

// File: rtl/tx_stage_fifo.sv
// Circular first-in first-out byte queue with an occupancy counter.
// Assumes: the push source checks 'room' before pushing; a pop
// against an empty queue is dropped. 'room' counts a pop in the
// same cycle as a free slot.
module tx_stage_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              room
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              full, pop_ok, push_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Derive status and qualified strobes from the occupancy count.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CW'(DEPTH));
        pop_ok  = pop && !empty && !clr;
        room    = !full || pop_ok;
        push_ok = push && room && !clr;
        head    = mem[rd_ptr];
    end

    // Advance pointers and count; clear resets all three.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // One write port per slot, selected by the write pointer.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Store the pushed byte into this slot when addressed.
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == AW'(g)) begin
                mem[g] <= push_data;
            end
        end
    end
endmodule

// File: rtl/tx_stage_sticky.sv
// Bank of sticky flags with write-one-to-clear; set outranks clear.
// Assumes: set and clear vectors are single-cycle strobes.
module tx_stage_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold the flag until software clears it without a new set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag[i] <= 1'b0;
            end else if (set[i]) begin
                flag[i] <= 1'b1;
            end else if (clr_mask[i]) begin
                flag[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_stage_buf.sv
// Transmit staging register in front of a byte queue for a bus target.
// Software writes the staging register; bytes move into the queue
// when it has room; the bus engine pops from the queue head.
// Assumes: synchronous active-low reset; sw_clr outranks writes.
module tx_stage_buf
    import tx_stage_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [DATA_W-1:0] sw_wr_data,
    input  logic              sw_clr,
    input  logic [1:0]        sw_err_clr,
    input  logic              bus_pop,
    input  logic              bus_rd_req,
    output logic [DATA_W-1:0] bus_data,
    output logic              hold_empty,
    output logic              tx_irq,
    output logic              fifo_nempty,
    output logic              wr_err,
    output logic              undr_err
);
    logic              hold_full, wr_bad, move;
    logic              q_empty, q_room;
    logic [DATA_W-1:0] hold_data;
    logic [NUM_STICKY-1:0] stk_set, stk_flag;

    tx_stage_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sw_clr),
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .move    (move),
        .full    (hold_full),
        .data    (hold_data),
        .wr_bad  (wr_bad)
    );

    tx_stage_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sw_clr),
        .push      (move),
        .push_data (hold_data),
        .pop       (bus_pop),
        .head      (bus_data),
        .empty     (q_empty),
        .room      (q_room)
    );

    tx_stage_sticky #(.N(NUM_STICKY)) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (stk_set),
        .clr_mask (sw_err_clr),
        .flag     (stk_flag)
    );

    // Transfer the staged byte and raise error events.
    always_comb begin
        move              = hold_full && q_room && !sw_clr;
        stk_set           = '0;
        stk_set[STK_WR]   = wr_bad;
        stk_set[STK_UNDR] = bus_rd_req && q_empty;
    end

    // Drive the status outputs.
    always_comb begin
        hold_empty  = !hold_full;
        tx_irq      = !hold_full;
        fifo_nempty = !q_empty;
        wr_err      = stk_flag[STK_WR];
        undr_err    = stk_flag[STK_UNDR];
    end
endmodule

// File: rtl/tx_stage_buf_chk.sv
// Port-level temporal checks for tx_stage_buf, attached by bind.
module tx_stage_buf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_wr_en,
    input logic       sw_clr,
    input logic [1:0] sw_err_clr,
    input logic       bus_pop,
    input logic       bus_rd_req,
    input logic       hold_empty,
    input logic       fifo_nempty,
    input logic       wr_err,
    input logic       undr_err
);
    // R3
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && hold_empty && !sw_clr |=> !hold_empty);
    // R6
    busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en && !hold_empty && !sw_clr |=> wr_err);
    // R9
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_req && !fifo_nempty |=> undr_err);
    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> hold_empty && !fifo_nempty);
    // R8
    nempty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_nempty && !sw_clr && !bus_pop |=> fifo_nempty);
    // R11
    wr_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err && !sw_err_clr[0] |=> wr_err);
endmodule

bind tx_stage_buf tx_stage_buf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_wr_en    (sw_wr_en),
    .sw_clr      (sw_clr),
    .sw_err_clr  (sw_err_clr),
    .bus_pop     (bus_pop),
    .bus_rd_req  (bus_rd_req),
    .hold_empty  (hold_empty),
    .fifo_nempty (fifo_nempty),
    .wr_err      (wr_err),
    .undr_err    (undr_err)
);

// File: tb/tx_stage_buf_tb.sv
module tx_stage_buf_tb;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              sw_wr_en, sw_clr, bus_pop, bus_rd_req;
    logic [DATA_W-1:0] sw_wr_data;
    logic [1:0]        sw_err_clr;
    logic [DATA_W-1:0] bus_data;
    logic              hold_empty, tx_irq, fifo_nempty, wr_err, undr_err;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    tx_stage_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_clr(sw_clr), .sw_err_clr(sw_err_clr), .bus_pop(bus_pop),
        .bus_rd_req(bus_rd_req), .bus_data(bus_data), .hold_empty(hold_empty),
        .tx_irq(tx_irq), .fifo_nempty(fifo_nempty), .wr_err(wr_err),
        .undr_err(undr_err)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct packed {
        logic       wr;
        logic [7:0] d;
        logic       pop;
        logic       rrq;
        logic       clr;
        logic [1:0] ec;
        logic       he;
        logic       ne;
        logic       we;
        logic       ue;
        logic [7:0] head;
    } vec_t;

    // Expected state after the edge on which each stimulus is applied.
    localparam vec_t VECS [12] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}, // R3
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA1}, // R4
        '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1}, // R3
        '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA1}, // R6
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'hB2}, // R7
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R8
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00}, // R9
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R11
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00}, // R11
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R11
        '{1'b1, 8'hD4, 1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}, // R10
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00}  // R12
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Apply one cycle of stimulus, then sample just after the edge.
    task automatic step(input logic wr, input logic [7:0] d, input logic pop,
                        input logic rrq, input logic clr, input logic [1:0] ec);
        @(negedge clk);
        sw_wr_en = wr; sw_wr_data = d; bus_pop = pop;
        bus_rd_req = rrq; sw_clr = clr; sw_err_clr = ec;
        @(posedge clk);
        #1;
        sw_wr_en = 1'b0; bus_pop = 1'b0; bus_rd_req = 1'b0;
        sw_clr = 1'b0; sw_err_clr = 2'b00;
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic chk_reset_state(input string tag);
        chk({tag, " hold_empty"}, int'(hold_empty), 1);
        chk({tag, " tx_irq"}, int'(tx_irq), 1);
        chk({tag, " fifo_nempty"}, int'(fifo_nempty), 0);
        chk({tag, " wr_err"}, int'(wr_err), 0);
        chk({tag, " undr_err"}, int'(undr_err), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0; sw_clr = 1'b0;
        sw_err_clr = 2'b00; bus_pop = 1'b0; bus_rd_req = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk_reset_state("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table-driven sequence.
        for (int i = 0; i < 12; i++) begin
            step(VECS[i].wr, VECS[i].d, VECS[i].pop, VECS[i].rrq, VECS[i].clr, VECS[i].ec);
            chk($sformatf("vec%0d hold_empty", i), int'(hold_empty), int'(VECS[i].he));
            chk($sformatf("vec%0d R2 tx_irq", i), int'(tx_irq), int'(VECS[i].he));
            chk($sformatf("vec%0d fifo_nempty", i), int'(fifo_nempty), int'(VECS[i].ne));
            chk($sformatf("vec%0d wr_err", i), int'(wr_err), int'(VECS[i].we));
            chk($sformatf("vec%0d undr_err", i), int'(undr_err), int'(VECS[i].ue));
            if (VECS[i].ne)
                chk($sformatf("vec%0d bus_data", i), int'(bus_data), int'(VECS[i].head));
        end

        // R5 R7: fill the queue to depth, then stage one more byte.
        for (int k = 0; k < DEPTH; k++) begin
            step(1'b1, 8'h10 + 8'(k), 1'b0, 1'b0, 1'b0, 2'b00);
            idle();
        end
        chk("R4 filled hold_empty", int'(hold_empty), 1);
        chk("R7 filled head", int'(bus_data), 'h10);
        step(1'b1, 8'h18, 1'b0, 1'b0, 1'b0, 2'b00);
        idle();
        chk("R5 stays staged while full", int'(hold_empty), 0);
        step(1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R6 write while staged", int'(wr_err), 1);
        chk("R5 still staged", int'(hold_empty), 0);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R11 clear wr_err", int'(wr_err), 0);
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 2'b00);
        chk("R9 request with data", int'(undr_err), 0);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R5 pop frees stage", int'(hold_empty), 1);
        chk("R7 head after pop", int'(bus_data), 'h11);
        for (int k = 1; k < DEPTH; k++) begin
            step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00);
            chk($sformatf("R7 drain head %0d", k), int'(bus_data), 'h11 + k);
            chk($sformatf("R8 still nonempty %0d", k), int'(fifo_nempty), 1);
        end
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R8 last pop empties", int'(fifo_nempty), 0);
        chk("R6 dropped byte absent", int'(hold_empty), 1);

        // R10: clear with queued and staged bytes keeps sticky flags.
        step(1'b1, 8'h21, 1'b0, 1'b0, 1'b0, 2'b00);
        idle();
        step(1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 2'b00);
        step(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 2'b00);
        step(1'b1, 8'h23, 1'b0, 1'b0, 1'b0, 2'b00);
        chk("R10 setup staged", int'(hold_empty), 0);
        step(1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 2'b00);
        chk("R10 clear hold_empty", int'(hold_empty), 1);
        chk("R10 clear fifo_nempty", int'(fifo_nempty), 0);
        chk("R10 clear keeps wr_err", int'(wr_err), 1);
        step(1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 2'b00);
        idle();
        chk("R10 queue restarts head", int'(bus_data), 'h30);
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b00);
        chk("R10 single entry after clear", int'(fifo_nempty), 0);

        // R1: reset in the middle of traffic.
        step(1'b1, 8'h41, 1'b0, 1'b1, 1'b0, 2'b00);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk_reset_state("R1 mid reset");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule